// File: doc/BRIEF.md
# Temperature Limit Event Unit

This block is the register and decision core of a digital temperature monitor. A converter outside the block delivers 13-bit two's complement readings (one count per 1/16 °C) on a strobed input. Software programs an upper, a lower and a critical threshold and a control word over a small parallel register bus with a 3-bit address. The block reports, with every reading, which thresholds are crossed, and it drives one event line.

The event can follow the temperature continuously (comparator mode), latch every window crossing until software acknowledges it (interrupt mode), or watch the critical threshold only. Hysteresis can delay the release of the upper thresholds, and the event line's polarity and enable are programmable. Two sticky lock bits freeze the thresholds and most control fields until reset. A shutdown bit freezes both the reading and the event. The event line is modelled as the enable of an open-drain pull-down.

Top module: `thermal_event_unit`

## Requirements
- R1: After reset, reads return 0x007F at address 0, 0x1B09 at address 6 and 0x2230 at address 7. Addresses 1 to 4 read 0x0000, and the event line is released (`evt_drive_low` = 0).
- R2: The threshold registers (address 2 upper, 3 lower, 4 critical) keep only write bits 12..2 (0.25 °C steps). Bits 15..13 and 1..0 read as 0.
- R3: A strobed reading is stored in bits 12..0 of address 5, which is read only. In that register bit 15 = (reading ≥ critical), bit 14 = (reading > upper) and bit 13 = (reading < lower), all signed and independent of the event settings.
- R4: Control bits 10:9 select the hysteresis (00 none, 01 1.5 °C, 10 3 °C, 11 6 °C). An active upper condition is released only when the reading is ≤ upper − hysteresis. An active critical condition is released only when the reading is < critical − hysteresis. The lower condition has no hysteresis.
- R5: In comparator mode (control bit 0 = 0, bit 2 = 0) the event is true while any of the three conditions holds. Control bit 4 reads as event AND enable (bit 3).
- R6: In interrupt mode (bit 0 = 1, bit 2 = 0), any change of the window state (upper or lower condition) latches the event. Writing 1 to control bit 5 clears the latch, and bit 5 always reads 0.
- R7: In interrupt mode, the event stays true while the critical condition holds. A clear written then takes effect once the critical condition ends.
- R8: With bit 2 = 1 the event equals the critical condition, and clear writes are ignored.
- R9: `evt_drive_low` = enable ? (bit 1 ? not event : event) : bit 1. Bit 1 = 1 is active high.
- R10: Bit 6 (alarm lock) and bit 7 (critical lock) are cleared only by reset. While either is set, bits 0, 1, 3, 10:9 keep their value and bit 8 cannot be set. While bit 6 is set, bit 2 cannot be set and the upper and lower thresholds cannot be written. While bit 7 is set, the critical threshold cannot be written.
- R11: While bit 8 (shutdown) is set, strobed readings are discarded and the event holds its value. A clear write during shutdown still de-asserts the event.
- R12: A threshold write changes the event without any new reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe for a new temperature reading |
| smp_temp | input | 13 | Reading, two's complement, 1/16 °C per count |
| bus_addr | input | 3 | Register address for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid one cycle after the address |
| evt_drive_low | output | 1 | Open-drain enable: 1 pulls the event line low |

## Verification
The assertions rely on three assumptions about the inputs. The reading input is a 13-bit two's complement value. A write to the control register is a single-cycle strobe. Shutdown, mode and lock fields change only through such writes. The stimulus applies one reading or one register write at a time and waits several cycles before it observes any result. Readings are held well clear of the thresholds, except where a hysteresis band or an equality boundary is the point of the test. The latched, deferred and frozen event paths are each reached from a known window state. Lock and shutdown are entered last, because nothing but reset undoes the locks.

// File: rtl/teu_pkg.sv
package teu_pkg;

  typedef enum logic [2:0] {
    RA_CAP  = 3'd0,
    RA_CFG  = 3'd1,
    RA_HIGH = 3'd2,
    RA_LOW  = 3'd3,
    RA_CRIT = 3'd4,
    RA_TEMP = 3'd5,
    RA_MFG  = 3'd6,
    RA_DEV  = 3'd7
  } reg_addr_e;

  // control word fields (bit position in the register noted beside each)
  typedef struct packed {
    logic [1:0] hyst;      // 10:9
    logic       shdn;      // 8
    logic       lk_crit;   // 7
    logic       lk_alm;    // 6
    logic       en;        // 3
    logic       crit_only; // 2
    logic       pol;       // 1
    logic       int_mode;  // 0
  } cfg_t;

  localparam int HYST_W = 7;

  // hysteresis in 1/16 degree counts
  function automatic logic [HYST_W-1:0] hyst_amt(input logic [1:0] sel);
    case (sel)
      2'b01:   hyst_amt = 7'd24;
      2'b10:   hyst_amt = 7'd48;
      2'b11:   hyst_amt = 7'd96;
      default: hyst_amt = 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/teu_lim_regs.sv
module teu_lim_regs
  import teu_pkg::*;
#(
  parameter int TEMP_W  = 13,
  parameter int DATA_W  = 16,
  parameter int LIM_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg_q,
  output logic              clr_req,
  output logic [TEMP_W-1:0] hi_lim,
  output logic [TEMP_W-1:0] lo_lim,
  output logic [TEMP_W-1:0] cr_lim
);

  localparam int LIM_W = TEMP_W - LIM_LSB;
  localparam int N_LIM = 3;

  logic [LIM_W-1:0] lim_q [N_LIM];
  cfg_t             cfg_d;
  logic             cfg_wr;
  logic             lock_any;
  logic             unused_bits;

  assign unused_bits = ^wr_data[DATA_W-1:TEMP_W];
  assign cfg_wr      = wr_en && (wr_addr == RA_CFG);
  assign lock_any    = cfg_q.lk_alm | cfg_q.lk_crit;
  assign clr_req     = cfg_wr && wr_data[5];

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) begin
      if (!lock_any) begin
        cfg_d.int_mode = wr_data[0];
        cfg_d.pol      = wr_data[1];
        cfg_d.en       = wr_data[3];
        cfg_d.hyst     = wr_data[10:9];
      end
      cfg_d.crit_only = wr_data[2] & (~cfg_q.lk_alm | cfg_q.crit_only);
      cfg_d.shdn      = wr_data[8] & (~lock_any | cfg_q.shdn);
      cfg_d.lk_alm    = cfg_q.lk_alm  | wr_data[6];
      cfg_d.lk_crit   = cfg_q.lk_crit | wr_data[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end

  // limit index 0 upper, 1 lower, 2 critical; addresses follow in that order
  for (genvar i = 0; i < N_LIM; i++) begin : g_lim
    localparam logic [2:0] LA = 3'(2 + i);
    logic locked;
    assign locked = (i == N_LIM - 1) ? cfg_q.lk_crit : cfg_q.lk_alm;
    always_ff @(posedge clk) begin
      if (rst)
        lim_q[i] <= '0;
      else if (wr_en && (wr_addr == LA) && !locked)
        lim_q[i] <= wr_data[TEMP_W-1:LIM_LSB];
    end
  end

  assign hi_lim = {lim_q[0], {LIM_LSB{1'b0}}};
  assign lo_lim = {lim_q[1], {LIM_LSB{1'b0}}};
  assign cr_lim = {lim_q[2], {LIM_LSB{1'b0}}};

endmodule

// File: rtl/teu_thresh.sv
module teu_thresh
  import teu_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [1:0]        hyst_sel,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] hi_lim,
  input  logic [TEMP_W-1:0] lo_lim,
  input  logic [TEMP_W-1:0] cr_lim,
  output logic              hi_nx,
  output logic              lo_nx,
  output logic              cr_nx,
  output logic              hi_q,
  output logic              lo_q,
  output logic [2:0]        trip
);

  localparam int EW = TEMP_W + 2;

  logic signed [EW-1:0] t_s, hi_s, lo_s, cr_s, h_s;
  logic                 cr_q;

  always_comb begin
    t_s  = $signed({{2{temp[TEMP_W-1]}},   temp});
    hi_s = $signed({{2{hi_lim[TEMP_W-1]}}, hi_lim});
    lo_s = $signed({{2{lo_lim[TEMP_W-1]}}, lo_lim});
    cr_s = $signed({{2{cr_lim[TEMP_W-1]}}, cr_lim});
    h_s  = $signed({{(EW-HYST_W){1'b0}}, hyst_amt(hyst_sel)});
    // raw status: critical, upper, lower
    trip[2] = (t_s >= cr_s);
    trip[1] = (t_s >  hi_s);
    trip[0] = (t_s <  lo_s);
    // event conditions with release delayed by hysteresis
    hi_nx = hi_q ? (t_s >  (hi_s - h_s)) : trip[1];
    cr_nx = cr_q ? (t_s >= (cr_s - h_s)) : trip[2];
    lo_nx = trip[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      cr_q <= 1'b0;
    end else if (!hold) begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
      cr_q <= cr_nx;
    end
  end

endmodule

// File: rtl/teu_event.sv
module teu_event (
  input  logic clk,
  input  logic rst,
  input  logic shdn,
  input  logic crit_only,
  input  logic int_mode,
  input  logic en,
  input  logic pol,
  input  logic clr_req,
  input  logic hi_nx,
  input  logic lo_nx,
  input  logic cr_nx,
  input  logic hi_q,
  input  logic lo_q,
  output logic evt_q,
  output logic drive_low_q
);

  logic latch_q, latch_d;
  logic pend_q, pend_d;
  logic evt_d;
  logic crossing;
  logic release_now;

  assign crossing    = (hi_nx | lo_nx) != (hi_q | lo_q);
  assign release_now = (clr_req | pend_q) & ~cr_nx;

  always_comb begin
    latch_d = 1'b0;
    pend_d  = 1'b0;
    evt_d   = 1'b0;
    if (shdn) begin
      latch_d = clr_req ? 1'b0 : latch_q;
      pend_d  = clr_req ? 1'b0 : pend_q;
      evt_d   = clr_req ? 1'b0 : evt_q;
    end else if (crit_only) begin
      evt_d = cr_nx;
    end else if (int_mode) begin
      if (crossing)         latch_d = 1'b1;
      else if (release_now) latch_d = 1'b0;
      else                  latch_d = latch_q;
      pend_d = (clr_req | pend_q) & cr_nx;
      evt_d  = latch_d | cr_nx;
    end else begin
      evt_d = hi_nx | lo_nx | cr_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q     <= 1'b0;
      pend_q      <= 1'b0;
      evt_q       <= 1'b0;
      drive_low_q <= 1'b0;
    end else begin
      latch_q     <= latch_d;
      pend_q      <= pend_d;
      evt_q       <= evt_d;
      drive_low_q <= en ? (pol ? ~evt_d : evt_d) : pol;
    end
  end

endmodule

// File: rtl/thermal_event_unit.sv
module thermal_event_unit
  import teu_pkg::*;
#(
  parameter int          TEMP_W  = 13,
  parameter int          DATA_W  = 16,
  parameter int          ADDR_W  = 3,
  parameter int          LIM_LSB = 2,
  parameter logic [15:0] CAP_VAL = 16'h007F,
  parameter logic [15:0] MFG_VAL = 16'h1B09,
  parameter logic [15:0] DEV_VAL = 16'h2230
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp_temp,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              evt_drive_low
);

  localparam int PAD_W = DATA_W - TEMP_W;

  cfg_t              cfg_q;
  logic              clr_req;
  logic [TEMP_W-1:0] hi_lim, lo_lim, cr_lim;
  logic [TEMP_W-1:0] temp_q;
  logic              hi_nx, lo_nx, cr_nx, hi_q, lo_q;
  logic [2:0]        trip;
  logic              evt_q;
  logic              c_shdn, c_crit_only, c_int_mode, c_en, c_pol, c_lk_alm, c_lk_crit;

  assign c_shdn      = cfg_q.shdn;
  assign c_crit_only = cfg_q.crit_only;
  assign c_int_mode  = cfg_q.int_mode;
  assign c_en        = cfg_q.en;
  assign c_pol       = cfg_q.pol;
  assign c_lk_alm    = cfg_q.lk_alm;
  assign c_lk_crit   = cfg_q.lk_crit;

  teu_lim_regs #(.TEMP_W(TEMP_W), .DATA_W(DATA_W), .LIM_LSB(LIM_LSB)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_we),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .cfg_q   (cfg_q),
    .clr_req (clr_req),
    .hi_lim  (hi_lim),
    .lo_lim  (lo_lim),
    .cr_lim  (cr_lim)
  );

  always_ff @(posedge clk) begin
    if (rst)                      temp_q <= '0;
    else if (smp_valid && !c_shdn) temp_q <= smp_temp;
  end

  teu_thresh #(.TEMP_W(TEMP_W)) u_thr (
    .clk      (clk),
    .rst      (rst),
    .hold     (c_shdn),
    .hyst_sel (cfg_q.hyst),
    .temp     (temp_q),
    .hi_lim   (hi_lim),
    .lo_lim   (lo_lim),
    .cr_lim   (cr_lim),
    .hi_nx    (hi_nx),
    .lo_nx    (lo_nx),
    .cr_nx    (cr_nx),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .trip     (trip)
  );

  teu_event u_evt (
    .clk         (clk),
    .rst         (rst),
    .shdn        (c_shdn),
    .crit_only   (c_crit_only),
    .int_mode    (c_int_mode),
    .en          (c_en),
    .pol         (c_pol),
    .clr_req     (clr_req),
    .hi_nx       (hi_nx),
    .lo_nx       (lo_nx),
    .cr_nx       (cr_nx),
    .hi_q        (hi_q),
    .lo_q        (lo_q),
    .evt_q       (evt_q),
    .drive_low_q (evt_drive_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        RA_CAP:  bus_rdata <= CAP_VAL;
        RA_CFG:  bus_rdata <= {5'b0, cfg_q.hyst, c_shdn, c_lk_crit, c_lk_alm, 1'b0,
                               evt_q & c_en, c_en, c_crit_only, c_pol, c_int_mode};
        RA_HIGH: bus_rdata <= {{PAD_W{1'b0}}, hi_lim};
        RA_LOW:  bus_rdata <= {{PAD_W{1'b0}}, lo_lim};
        RA_CRIT: bus_rdata <= {{PAD_W{1'b0}}, cr_lim};
        RA_TEMP: bus_rdata <= {trip, temp_q};
        RA_MFG:  bus_rdata <= MFG_VAL;
        default: bus_rdata <= DEV_VAL;
      endcase
    end
  end

endmodule

// File: rtl/teu_chk.sv
module teu_chk (
  input logic clk,
  input logic rst,
  input logic c_shdn,
  input logic c_crit_only,
  input logic c_int_mode,
  input logic c_en,
  input logic c_pol,
  input logic c_lk_alm,
  input logic c_lk_crit,
  input logic clr_req,
  input logic hi_nx,
  input logic lo_nx,
  input logic cr_nx,
  input logic hi_q,
  input logic lo_q,
  input logic evt_q,
  input logic evt_drive_low
);

  p_alm_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    c_lk_alm |=> c_lk_alm);

  p_crit_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    c_lk_crit |=> c_lk_crit);

  p_shdn_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    (c_shdn && !clr_req) |=> $stable(evt_q));

  p_shdn_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (c_shdn && clr_req) |=> !evt_q);

  p_crit_only_r8: assert property (@(posedge clk) disable iff (rst)
    (!c_shdn && c_crit_only) |=> (evt_q == $past(cr_nx)));

  p_cmp_window_r5: assert property (@(posedge clk) disable iff (rst)
    (!c_shdn && !c_crit_only && !c_int_mode) |=> (evt_q == (hi_q | lo_q | $past(cr_nx))));

  p_int_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (!c_shdn && !c_crit_only && c_int_mode && ((hi_nx | lo_nx) != (hi_q | lo_q))) |=> evt_q);

  p_int_crit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!c_shdn && !c_crit_only && c_int_mode && cr_nx) |=> evt_q);

  p_disabled_pin_r9: assert property (@(posedge clk) disable iff (rst)
    !c_en |=> (evt_drive_low == $past(c_pol)));

endmodule

bind thermal_event_unit teu_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .c_shdn        (c_shdn),
  .c_crit_only   (c_crit_only),
  .c_int_mode    (c_int_mode),
  .c_en          (c_en),
  .c_pol         (c_pol),
  .c_lk_alm      (c_lk_alm),
  .c_lk_crit     (c_lk_crit),
  .clr_req       (clr_req),
  .hi_nx         (hi_nx),
  .lo_nx         (lo_nx),
  .cr_nx         (cr_nx),
  .hi_q          (hi_q),
  .lo_q          (lo_q),
  .evt_q         (evt_q),
  .evt_drive_low (evt_drive_low)
);

// File: tb/sim_thermal_event_unit.sv
module sim_thermal_event_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [12:0] smp_temp = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  wire  [15:0] bus_rdata;
  wire         evt_drive_low;

  always #10 clk = ~clk;

  thermal_event_unit u0 (
    .clk           (clk),
    .rst           (rst),
    .smp_valid     (smp_valid),
    .smp_temp      (smp_temp),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .evt_drive_low (evt_drive_low)
  );

  typedef struct {
    bit          is_pin;
    logic [15:0] exp;
    string       tag;
    int          at;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items when their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at == cyc) begin
      item_t       it;
      logic [15:0] act;
      it  = q.pop_front();
      act = it.is_pin ? {15'b0, evt_drive_low} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h (cycle %0d)", it.tag, act, it.exp, cyc);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    repeat (4) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step();
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
    settle();
  endtask

  task automatic smp(input logic [12:0] t);
    step();
    smp_temp = t; smp_valid = 1'b1;
    step();
    smp_valid = 1'b0;
    settle();
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    step();
    bus_addr = a;
    it.is_pin = 1'b0; it.exp = e; it.tag = tag; it.at = cyc + 1;
    q.push_back(it);
    step();
  endtask

  task automatic chk_pin(input logic e, input string tag);
    item_t it;
    step();
    it.is_pin = 1'b1; it.exp = {15'b0, e}; it.tag = tag; it.at = cyc;
    q.push_back(it);
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst = 1'b0;
    settle();

    // R1 reset state; R3 with all limits 0 a zero reading is at critical
    chk_rd(3'd0, 16'h007F, "R1 capability");
    chk_rd(3'd1, 16'h0000, "R1 control");
    chk_rd(3'd2, 16'h0000, "R1 upper");
    chk_rd(3'd3, 16'h0000, "R1 lower");
    chk_rd(3'd4, 16'h0000, "R1 critical");
    chk_rd(3'd5, 16'h8000, "R3 reset reading");
    chk_rd(3'd6, 16'h1B09, "R1 manufacturer");
    chk_rd(3'd7, 16'h2230, "R1 device");
    chk_pin(1'b0, "R1 pin released");

    // R2 stored bits
    wr(3'd2, 16'hFFFF);
    chk_rd(3'd2, 16'h1FFC, "R2 upper mask");
    wr(3'd3, 16'h00A3);
    chk_rd(3'd3, 16'h00A0, "R2 lower mask");
    wr(3'd2, 16'h0500);   // 80 C
    wr(3'd4, 16'h05F0);   // 95 C, lower is 10 C
    chk_rd(3'd5, 16'h2000, "R3 below lower");

    // R5 comparator, enabled, active low
    wr(3'd1, 16'h0008);
    chk_pin(1'b1, "R5 low event");
    chk_rd(3'd1, 16'h0018, "R5 status bit");
    smp(13'h0190);        // 25 C
    chk_pin(1'b0, "R5 inside window");
    chk_rd(3'd5, 16'h0190, "R3 inside");
    smp(13'h05A0);        // 90 C
    chk_pin(1'b1, "R5 above upper");
    chk_rd(3'd5, 16'h45A0, "R3 above upper");
    smp(13'h0640);        // 100 C
    chk_rd(3'd5, 16'hC640, "R3 above critical");
    smp(13'h1FB0);        // -5 C
    chk_rd(3'd5, 16'h3FB0, "R3 negative below lower");
    chk_pin(1'b1, "R5 negative");

    // R9 polarity and enable
    wr(3'd1, 16'h000A);
    chk_pin(1'b0, "R9 active high asserted");
    chk_rd(3'd1, 16'h001A, "R5 status active high");
    smp(13'h0190);
    chk_pin(1'b1, "R9 active high idle");
    wr(3'd1, 16'h0002);
    chk_pin(1'b1, "R9 disabled active high");
    chk_rd(3'd1, 16'h0002, "R5 status disabled");
    wr(3'd1, 16'h0000);
    chk_pin(1'b0, "R9 disabled active low");

    // R4 hysteresis 1.5 C
    wr(3'd1, 16'h0208);
    smp(13'h0510);        // 81 C
    chk_pin(1'b1, "R4 enter upper");
    smp(13'h04F0);        // 79 C, inside band
    chk_pin(1'b1, "R4 held by 1.5C band");
    chk_rd(3'd5, 16'h04F0, "R3 trip without hysteresis");
    smp(13'h04E0);        // 78 C
    chk_pin(1'b0, "R4 released 1.5C");
    // R4 hysteresis 6 C
    wr(3'd1, 16'h0608);
    smp(13'h0510);
    chk_pin(1'b1, "R4 enter upper 6C");
    smp(13'h04B0);        // 75 C
    chk_pin(1'b1, "R4 held by 6C band");
    smp(13'h0490);        // 73 C
    chk_pin(1'b0, "R4 released 6C");

    // R6 interrupt mode
    wr(3'd1, 16'h0009);
    chk_pin(1'b0, "R6 no crossing yet");
    smp(13'h0550);        // 85 C
    chk_pin(1'b1, "R6 latched out");
    smp(13'h0460);        // 70 C
    chk_pin(1'b1, "R6 latched back in");
    wr(3'd1, 16'h0029);
    chk_pin(1'b0, "R6 cleared");
    chk_rd(3'd1, 16'h0009, "R6 clear bit reads 0");
    smp(13'h0550);
    chk_pin(1'b1, "R6 latched again");
    wr(3'd1, 16'h0029);
    chk_pin(1'b0, "R6 stays cleared while outside");

    // R7 clear deferred above critical
    smp(13'h0460);
    smp(13'h0640);        // 100 C
    wr(3'd1, 16'h0029);
    chk_pin(1'b1, "R7 held above critical");
    smp(13'h05A0);        // 90 C
    chk_pin(1'b0, "R7 deferred clear applied");

    // R8 critical only
    wr(3'd1, 16'h000D);
    chk_pin(1'b0, "R8 below critical");
    smp(13'h0640);
    chk_pin(1'b1, "R8 above critical");
    wr(3'd1, 16'h002D);
    chk_pin(1'b1, "R8 clear ignored");
    smp(13'h05A0);
    chk_pin(1'b0, "R8 follows critical");
    smp(13'h0050);        // 5 C
    chk_pin(1'b0, "R8 lower ignored");

    // R12 limit write re-evaluates
    wr(3'd1, 16'h0008);
    chk_pin(1'b1, "R12 low before write");
    wr(3'd3, 16'h0040);   // 4 C
    chk_pin(1'b0, "R12 released by limit write");
    chk_rd(3'd5, 16'h0050, "R12 trip after write");

    // R11 shutdown
    wr(3'd3, 16'h00A0);
    chk_pin(1'b1, "R12 asserted by limit write");
    wr(3'd1, 16'h0108);
    smp(13'h0190);
    chk_rd(3'd5, 16'h2050, "R11 reading frozen");
    chk_pin(1'b1, "R11 event frozen");
    wr(3'd1, 16'h0128);
    chk_pin(1'b0, "R11 clear in shutdown");
    wr(3'd1, 16'h0008);
    chk_pin(1'b1, "R11 resumed");
    smp(13'h0190);
    chk_pin(1'b0, "R11 sampling resumed");
    chk_rd(3'd5, 16'h0190, "R11 new reading");

    // R10 locks
    wr(3'd1, 16'h0048);
    wr(3'd2, 16'h0100);
    chk_rd(3'd2, 16'h0500, "R10 upper locked");
    wr(3'd3, 16'h0000);
    chk_rd(3'd3, 16'h00A0, "R10 lower locked");
    wr(3'd1, 16'h0107);
    chk_rd(3'd1, 16'h0048, "R10 fields frozen");
    wr(3'd4, 16'h0600);
    chk_rd(3'd4, 16'h0600, "R10 critical writable");
    wr(3'd1, 16'h00C8);
    wr(3'd4, 16'h0700);
    chk_rd(3'd4, 16'h0600, "R10 critical locked");
    wr(3'd1, 16'h0008);
    chk_rd(3'd1, 16'h00C8, "R10 locks sticky");

    repeat (3) step();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule